// File: doc/BRIEF.md
# Predicated Vector Immediate Shifter

This block shifts every active lane of a packed vector by an amount taken from an instruction immediate. One 7-bit immediate holds both values. Its upper four bits are a size tag whose highest set bit picks the lane width: 8, 16, 32 or 64 bits. The tag and the low three bits together form a number from which the shift distance is derived. Four operations are available:

- arithmetic right shift;
- logical right shift;
- logical left shift;
- arithmetic right shift that rounds toward zero, as used for signed division by a power of two.

The destination is also the first source. Lanes whose predicate is clear keep the source contents; this is merging behaviour. A shift distance equal to the lane width is legal. Arithmetic shift clamps it, so each lane becomes copies of its sign bit. The logical shifts and the rounding shift write zero into active lanes instead. An immediate whose size tag is all zeros is an unallocated encoding. The block then flags it and returns the source vector untouched.

Each accepted operation appears on the output register one clock after `in_valid`, together with a one-cycle `out_valid` pulse.

Top module: `vsh_unit`

## Requirements
- R1: Lane width is 8 << e, where e (0 to 3) is the bit index of the highest set bit of `imm[6:3]`; lanes are packed from bit 0 of the vector upward.
- R2: When `imm[6:3]` is zero, the accepted operation sets `out_invalid` with its `out_valid` pulse and `out_vec` equals the source vector.
- R3: For right shifts (`op` 0 = arithmetic, 1 = logical, 3 = rounding) the distance is (16 << e) minus the 7-bit immediate value, giving 1 up to the lane width.
- R4: For the left shift (`op` 2) the distance is the immediate value minus (8 << e), giving 0 up to lane width minus 1.
- R5: Arithmetic right shift at a distance equal to the lane width behaves as a shift of lane width minus 1, filling the lane with its sign bit.
- R6: Logical right shift at a distance equal to the lane width writes zero into every active lane.
- R7: The rounding shift (`op` 3) rounds toward zero: a negative lane has 2^distance − 1 added before the arithmetic shift, and a non-negative lane is shifted unchanged.
- R8: The rounding shift at a distance equal to the lane width writes zero into every active lane.
- R9: A lane is active when the `pred` bit of its lowest byte is set (bit k of `pred` covers vector byte k); inactive lanes, including during zeroing, keep their source value.
- R10: `out_valid` is low after reset and pulses high exactly one cycle after each cycle with `in_valid` high; back-to-back inputs give back-to-back results.
- R11: `out_invalid` is never high without `out_valid`, and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | 0 arithmetic right, 1 logical right, 2 logical left, 3 rounding right |
| imm | input | 7 | Packed size tag [6:3] and low immediate [2:0] |
| src_vec | input | VEC_W | Destination/first source vector |
| pred | input | VEC_W/8 | One predicate bit per byte |
| out_valid | output | 1 | Result valid pulse |
| out_invalid | output | 1 | Unallocated immediate reported with the result |
| out_vec | output | VEC_W | Result vector |

## Verification
The two functions that can fall in the same cycle are lane zeroing and predicate merging. A zeroing shift, at a distance equal to the lane width, must clear active lanes and leave the lanes between them untouched. The bench provokes this with a partial predicate whose bits fall on non-lowest bytes of some lanes. It issues logical and rounding shifts at full width under that predicate, and compares the whole vector against an independent per-lane model. Arithmetic clamping is run under the same kind of mixed predicate.

// File: rtl/vsh_pkg.sv
package vsh_pkg;
  typedef enum logic [1:0] {
    OP_ASR  = 2'd0,
    OP_LSR  = 2'd1,
    OP_LSL  = 2'd2,
    OP_ASRD = 2'd3
  } shop_e;

  localparam int IMM_W = 7;
  localparam int TAG_W = 4;
  localparam int AMT_W = 8;
  localparam int NSIZE = 4;
endpackage

// File: rtl/vsh_decode.sv
module vsh_decode
  import vsh_pkg::*;
(
  input  logic [IMM_W-1:0] imm,
  input  shop_e            op,
  output logic [1:0]       esz,
  output logic             bad,
  output logic [AMT_W-1:0] amt,
  output logic [AMT_W-1:0] eff,
  output logic             zero
);
  logic [TAG_W-1:0] tag;
  logic [AMT_W-1:0] lane_w;
  logic [AMT_W-1:0] imm_x;

  always_comb begin
    tag   = imm[IMM_W-1:IMM_W-TAG_W];
    imm_x = {1'b0, imm};
    bad   = (tag == '0);
    // R1: highest set bit of the tag selects the lane size
    if (tag[3])      esz = 2'd3;
    else if (tag[2]) esz = 2'd2;
    else if (tag[1]) esz = 2'd1;
    else             esz = 2'd0;
    lane_w = AMT_W'(8) << esz;
    // R3 / R4: distance depends on shift direction
    if (op == OP_LSL) amt = imm_x - lane_w;
    else              amt = (AMT_W'(16) << esz) - imm_x;
    eff  = amt;
    zero = 1'b0;
    unique case (op)
      OP_ASR:  if (amt >= lane_w) eff = lane_w - AMT_W'(1);   // R5 clamp
      default: if (amt >= lane_w) zero = 1'b1;                // R6 / R8
    endcase
  end
endmodule

// File: rtl/vsh_lane.sv
module vsh_lane
  import vsh_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     x,
  input  shop_e            op,
  input  logic [AMT_W-1:0] sh,
  input  logic             zero,
  output logic [W-1:0]     y
);
  logic [W-1:0] mask;
  logic [W-1:0] bias;
  logic [W-1:0] sum;

  always_comb begin
    mask = ~({W{1'b1}} << sh);
    bias = x[W-1] ? mask : '0;   // R7: round toward zero for negative lanes
    sum  = x + bias;
    unique case (op)
      OP_ASR:  y = W'($signed(x) >>> sh);
      OP_LSR:  y = x >> sh;
      OP_LSL:  y = x << sh;
      default: y = W'($signed(sum) >>> sh);
    endcase
    if (zero) y = '0;
  end
endmodule

// File: rtl/vsh_lanes.sv
module vsh_lanes
  import vsh_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int LW    = 8
) (
  input  logic [VEC_W-1:0]   src,
  input  logic [VEC_W/8-1:0] pred,
  input  shop_e              op,
  input  logic [AMT_W-1:0]   sh,
  input  logic               zero,
  output logic [VEC_W-1:0]   res
);
  localparam int NL = VEC_W / LW;
  localparam int PB = LW / 8;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [LW-1:0] y;
    vsh_lane #(.W(LW)) u_lane (
      .x    (src[i*LW +: LW]),
      .op   (op),
      .sh   (sh),
      .zero (zero),
      .y    (y)
    );
    // R9: lowest-byte predicate governs the lane; inactive lanes merge
    assign res[i*LW +: LW] = pred[i*PB] ? y : src[i*LW +: LW];
  end
endmodule

// File: rtl/vsh_unit.sv
module vsh_unit
  import vsh_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         op,
  input  logic [IMM_W-1:0]   imm,
  input  logic [VEC_W-1:0]   src_vec,
  input  logic [VEC_W/8-1:0] pred,
  output logic               out_valid,
  output logic               out_invalid,
  output logic [VEC_W-1:0]   out_vec
);
  localparam int PW = VEC_W / 8;

  shop_e            op_e;
  logic [1:0]       dec_esz;
  logic             dec_bad;
  logic [AMT_W-1:0] dec_amt;
  logic [AMT_W-1:0] dec_eff;
  logic             dec_zero;
  logic [VEC_W-1:0] cand [NSIZE];
  logic [VEC_W-1:0] nxt_vec;
  logic             nxt_valid;
  logic             nxt_invalid;

  assign op_e = shop_e'(op);

  vsh_decode u_dec (
    .imm  (imm),
    .op   (op_e),
    .esz  (dec_esz),
    .bad  (dec_bad),
    .amt  (dec_amt),
    .eff  (dec_eff),
    .zero (dec_zero)
  );

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    vsh_lanes #(.VEC_W(VEC_W), .LW(8 << g)) u_lanes (
      .src  (src_vec),
      .pred (pred),
      .op   (op_e),
      .sh   (dec_eff),
      .zero (dec_zero),
      .res  (cand[g])
    );
  end

  always_comb begin
    nxt_valid   = in_valid;
    nxt_invalid = in_valid & dec_bad;
    nxt_vec     = dec_bad ? src_vec : cand[dec_esz];   // R2: keep destination
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid   <= nxt_valid;
      out_invalid <= nxt_invalid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vec <= '0;
    else if (in_valid) out_vec <= nxt_vec;
  end

  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_invalid_with_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> out_valid);
  p_bad_keeps_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && imm[6:3] == '0) |=> (out_invalid && out_vec == $past(src_vec)));
  p_right_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_bad && op_e != OP_LSL) |->
      (dec_amt >= AMT_W'(1) && dec_amt <= (AMT_W'(8) << dec_esz)));
  p_left_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_bad && op_e == OP_LSL) |-> (dec_amt < (AMT_W'(8) << dec_esz)));
  p_lsr_full_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == OP_LSR && imm[2:0] == 3'd0 && $countones(imm[6:3]) == 1
     && pred == {PW{1'b1}}) |=> (out_vec == '0));
  p_no_pred_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred == '0) |=> (out_vec == $past(src_vec)));
endmodule

// File: tb/sim_vsh_unit.sv
module sim_vsh_unit;
  localparam int VW = 128;
  localparam int PW = VW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    op = '0;
  logic [6:0]    imm = '0;
  logic [VW-1:0] src_vec = '0;
  logic [PW-1:0] pred = '0;
  logic          out_valid;
  logic          out_invalid;
  logic [VW-1:0] out_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vsh_unit #(.VEC_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .imm(imm),
    .src_vec(src_vec), .pred(pred), .out_valid(out_valid),
    .out_invalid(out_invalid), .out_vec(out_vec)
  );

  function automatic logic [VW-1:0] model(input logic [1:0] o, input logic [6:0] im,
                                          input logic [VW-1:0] s, input logic [PW-1:0] p);
    int e, w, sh, s2;
    logic [VW-1:0] r;
    logic [63:0] x, y;
    logic signed [65:0] sx, dv;
    if (im[6:3] == 4'd0) return s;
    e = im[6] ? 3 : im[5] ? 2 : im[4] ? 1 : 0;
    w = 8 << e;
    if (o == 2'd2) sh = int'(im) - w;
    else           sh = (16 << e) - int'(im);
    r = s;
    for (int i = 0; i < VW / w; i++) begin
      if (p[i * w / 8]) begin
        x = '0;
        for (int b = 0; b < w; b++) x[b] = s[i*w + b];
        sx = {2'b00, x};
        if (x[w-1]) for (int b = w; b < 66; b++) sx[b] = 1'b1;
        case (o)
          2'd0: begin s2 = (sh >= w) ? w - 1 : sh; y = 64'(sx >>> s2); end
          2'd1: y = (sh >= w) ? 64'd0 : x >> sh;
          2'd2: y = (sh >= w) ? 64'd0 : x << sh;
          default: begin
            if (sh >= w) y = 64'd0;
            else begin dv = 66'sd1 <<< sh; y = 64'(sx / dv); end
          end
        endcase
        for (int b = 0; b < w; b++) r[i*w + b] = y[b];
      end
    end
    return r;
  endfunction

  task automatic check_vec(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s vec act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s flag act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic run_one(input string tag, input logic [1:0] o, input logic [6:0] im,
                         input logic [VW-1:0] s, input logic [PW-1:0] p);
    @(negedge clk);
    op = o; imm = im; src_vec = s; pred = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({tag, " valid"}, out_valid, 1'b1);
    check_bit({tag, " invalid"}, out_invalid, im[6:3] == 4'd0);
    check_vec(tag, out_vec, model(o, im, s, p));
  endtask

  localparam logic [VW-1:0] PAT = 128'h80FF_7F01_F9C3_0000_8000_0001_FFFF_FFF9;
  localparam logic [VW-1:0] PAT2 = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;

  task automatic t_reset;
    check_bit("R10 reset valid", out_valid, 1'b0);
    check_bit("R11 reset invalid", out_invalid, 1'b0);
  endtask

  task automatic t_sizes;   // R1, R3, R4 across every lane size
    for (int e = 0; e < 4; e++) begin
      run_one("R1 R3 asr", 2'd0, 7'((8 << e) + 3), PAT, '1);
      run_one("R1 R3 lsr", 2'd1, 7'((8 << e) + 5), PAT2, '1);
      run_one("R4 lsl min", 2'd2, 7'(8 << e), PAT, '1);
      run_one("R4 lsl max", 2'd2, 7'((16 << e) - 1), PAT2, '1);
    end
  endtask

  task automatic t_full_width;   // R5, R6, R8 with mixed predicate
    for (int e = 0; e < 4; e++) begin
      run_one("R5 asr clamp", 2'd0, 7'(8 << e), PAT, 16'hA5F1);
      run_one("R6 lsr zero", 2'd1, 7'(8 << e), PAT2, 16'h5A3C);
      run_one("R8 asrd zero", 2'd3, 7'(8 << e), PAT, 16'hC3E7);
    end
    // ASRD one below the width must not zero
    run_one("R8 asrd w-1", 2'd3, 7'd9, PAT, '1);
  endtask

  task automatic t_asrd_round;   // R7: hand values, 8-bit lanes
    // lane0 = -7 >> 1 toward zero = -3 (FD); lane1 = 7 >> 1 = 3
    run_one("R7 asrd", 2'd3, 7'd15, {112'h0, 16'h07F9}, '1);
    check_vec("R7 hand", out_vec, {112'h0, 16'h03FD});
    for (int e = 0; e < 4; e++)
      run_one("R7 asrd sizes", 2'd3, 7'((16 << e) - 2), PAT, '1);
  endtask

  task automatic t_invalid;   // R2
    run_one("R2 bad lsr", 2'd1, 7'd0, PAT, '1);
    check_vec("R2 src", out_vec, PAT);
    run_one("R2 bad asr", 2'd0, 7'd7, PAT2, '1);
  endtask

  task automatic t_predicate;   // R9
    run_one("R9 none", 2'd2, 7'd12, PAT, '0);
    check_vec("R9 none src", out_vec, PAT);
    // 32-bit lanes: only non-lowest byte bits set -> all lanes keep source
    run_one("R9 upper bytes", 2'd1, 7'd40, PAT2, 16'hEEEE);
    check_vec("R9 upper src", out_vec, PAT2);
    run_one("R9 lowest bytes", 2'd1, 7'd40, PAT2, 16'h1111);
  endtask

  task automatic t_pipeline;   // R10, R11
    @(negedge clk);
    op = 2'd2; imm = 7'd9; src_vec = PAT; pred = '1; in_valid = 1'b1;
    @(negedge clk);
    check_bit("R10 b2b first", out_valid, 1'b1);
    check_vec("R10 b2b first", out_vec, model(2'd2, 7'd9, PAT, '1));
    op = 2'd1; imm = 7'd0; src_vec = PAT2;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R10 b2b second", out_valid, 1'b1);
    check_bit("R11 b2b invalid", out_invalid, 1'b1);
    check_vec("R10 b2b second", out_vec, PAT2);
    @(negedge clk);
    check_bit("R10 idle", out_valid, 1'b0);
    check_bit("R11 idle", out_invalid, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_sizes();
    t_full_width();
    t_asrd_round();
    t_invalid();
    t_predicate();
    t_pipeline();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule